// File: doc/BRIEF.md
# I2C Target Port with Event Flags

This block is the target (slave) side of an I2C bus for 7-bit addressing. It samples the bus clock and data lines through a short synchroniser. After a START it shifts in an address byte. It answers with ACK when the byte carries its programmed address, or the general-call address 0x00 when general call is enabled. It then receives or sends data bytes. Every bus event that software must see raises a flag in a status register. Each flag has its own bit in an enable register, and the interrupt output is the OR of the flags whose enable bits are set.

Software reaches the block through a small register port: a write strobe, a read strobe, a 3-bit register address, and an 8-bit read and write data path. Read data is registered and is valid on the cycle after the read strobe. Flags that need a software action before the bus may go on are the address flag, the received flag and the empty flag. While any of them is pending, the block holds SCL low. The data line and the clock line are driven only as open-drain pull-downs.

Top module: `i2c_target`

## Requirements
- R1: After reset the status, control and enable registers read 0, and `sda_oe`, `scl_oe` and `irq` are low.
- R2: A START followed by an address byte whose upper seven bits equal the own-address register (address 3, bits 6:0, nonzero) is acknowledged. It sets status bit 0, and the data register (address 4) then reads the whole address byte, R/W bit included.
- R3: An address byte that matches neither address is not acknowledged and sets no flag. Address 0x00 is acknowledged only while control bit 1 (general-call enable) is set, and it then also sets status bit 6.
- R4: Status bit 5 takes the R/W bit of each matched address byte (1 = master reads). Status writes do not change it.
- R5: In a write transfer each received data byte is stored in the data register, sets status bit 1 and is acknowledged.
- R6: While control bit 0 (forced NACK) is set, the next received data byte is answered with NACK. The bit then clears itself, so the following byte is acknowledged again.
- R7: In a read transfer the data register is moved to the shifter at the end of the address ACK and after every master ACK. Each move sets status bit 3. Bytes go out MSB first. Status bit 2 is set after each byte, and a master NACK ends the transfer.
- R8: A STOP while enabled sets status bit 4 and returns the block to idle. Clock pulses after it, without a new START, are ignored.
- R9: Writing the status register (address 1) clears each flag written as 0 and leaves each flag written as 1 unchanged.
- R10: `irq` is high exactly when a status bit and the same bit of the enable register (address 2) are both set. It follows a register write by one cycle.
- R11: While status bit 0, 1 or 3 is pending, the block holds SCL low once SCL has gone low. It releases SCL after those flags are cleared.
- R12: While control bit 2 (interface enable) is clear, the block drives neither line and sets no flag, not even on STOP. Control bit 3 is held and read back only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| scl_oe | output | 1 | Pull the clock line low (stretch) |
| sda_oe | output | 1 | Pull the data line low (ACK or 0 bit) |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid the cycle after `reg_re` |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the cycle-level rules on every cycle:
- `irq` only rises with an enabled flag present.
- SCL is stretched only when a pending flag asks for it, and always when one does.
- A status bit written as 0 is cleared, and forced NACK clears itself once used.
- A STOP sends the state machine back to idle.
- No pull-down is driven while the interface is disabled.

Only the bench's bus scenarios can show that:
- bytes move in the right bit order;
- address filtering and general call accept and refuse as specified;
- transmit refills happen at the right ACKs;
- the sequence of flags over whole write and read transfers is correct.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  // status bit positions
  localparam int SB_ADR = 0;
  localparam int SB_RXD = 1;
  localparam int SB_TXD = 2;
  localparam int SB_EMP = 3;
  localparam int SB_STP = 4;
  localparam int SB_MOD = 5;
  localparam int SB_GCL = 6;

  // control bit positions
  localparam int CB_NAK = 0;
  localparam int CB_GCE = 1;
  localparam int CB_EN  = 2;
  localparam int CB_BUF = 3;
  localparam int CTRL_W = 4;

  // register addresses
  localparam int RA_CTRL = 0;
  localparam int RA_STAT = 1;
  localparam int RA_IEN  = 2;
  localparam int RA_OWN  = 3;
  localparam int RA_DATA = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK
  } tgt_state_t;

  typedef struct packed {
    logic addr_hit;
    logic gcall;
    logic rw;
    logic rx_done;
    logic nack_used;
    logic tx_load;
    logic tx_sent;
    logic stop;
  } tgt_evt_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              gce,
  input  logic              fna,
  input  logic [6:0]        own,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_oe,
  output tgt_evt_t          evt,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  tgt_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              rw_q, mack;
  logic              hit_own, hit_gc;

  assign hit_gc  = gce && (sh[BYTE_W-1:1] == 7'd0);
  assign hit_own = (sh[BYTE_W-1:1] == own) && (own != 7'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      rw_q    <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
      evt     <= '0;
      rx_byte <= '0;
    end else begin
      evt <= '0;
      if (!en) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_oe   <= 1'b0;
        evt.stop <= 1'b1;
      end else if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              if (hit_own || hit_gc) begin
                state        <= ST_AACK;
                sda_oe       <= 1'b1;
                rw_q         <= sh[0];
                rx_byte      <= sh;
                evt.addr_hit <= 1'b1;
                evt.gcall    <= hit_gc;
                evt.rw       <= sh[0];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK, ST_TACK: begin
            if (state == ST_TACK && scl_rise) mack <= ~sda_s;
            if (scl_fall) begin
              cnt <= '0;
              if ((state == ST_AACK && rw_q) || (state == ST_TACK && mack)) begin
                state       <= ST_TX;
                sh          <= tx_byte;
                sda_oe      <= ~tx_byte[BYTE_W-1];
                evt.tx_load <= 1'b1;
              end else if (state == ST_AACK) begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
              end else begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              rx_byte       <= sh;
              evt.rx_done   <= 1'b1;
              evt.nack_used <= fna;
              sda_oe        <= ~fna;
              state         <= ST_RACK;
            end
          end
          ST_RACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              sda_oe      <= 1'b0;
              evt.tx_sent <= 1'b1;
              state       <= ST_TACK;
            end else if (scl_fall && cnt != '0) begin
              sh     <= {sh[BYTE_W-2:0], 1'b0};
              sda_oe <= ~sh[BYTE_W-2];
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8: a STOP always lands in idle with the data line released
  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (en && stop_det) |=> (state == ST_IDLE && !sda_oe));

  // R12: nothing is driven while the interface is off
  assert_quiet_off_R12: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sda_oe);
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [REG_AW-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  tgt_evt_t          evt,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] rdata,
  output logic              en,
  output logic              gce,
  output logic              fna,
  output logic [6:0]        own,
  output logic [BYTE_W-1:0] data_q,
  output logic              hold_any,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] st_q, st_n, ien_q, ien_n, wmask, setv;
  logic              wr_st, wr_ctl;

  assign wr_st  = we && (addr == REG_AW'(RA_STAT));
  assign wr_ctl = we && (addr == REG_AW'(RA_CTRL));

  always_comb begin
    wmask = wr_st ? wdata : '1;
    setv = '0;
    setv[SB_ADR] = evt.addr_hit;
    setv[SB_GCL] = evt.addr_hit & evt.gcall;
    setv[SB_RXD] = evt.rx_done;
    setv[SB_EMP] = evt.tx_load;
    setv[SB_TXD] = evt.tx_sent;
    setv[SB_STP] = evt.stop;
    st_n = (st_q & wmask) | setv;
    st_n[SB_MOD] = evt.addr_hit ? evt.rw : st_q[SB_MOD];
    st_n[BYTE_W-1] = 1'b0;
    ien_n = (we && addr == REG_AW'(RA_IEN)) ? wdata : ien_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      st_q   <= '0;
      ien_q  <= '0;
      own    <= '0;
      data_q <= '0;
      rdata  <= '0;
      irq    <= 1'b0;
    end else begin
      st_q  <= st_n;
      ien_q <= ien_n;
      irq   <= |(st_n & ien_n);
      if (wr_ctl) ctrl_q <= wdata[CTRL_W-1:0];
      else if (evt.nack_used) ctrl_q[CB_NAK] <= 1'b0;
      if (we && addr == REG_AW'(RA_OWN)) own <= wdata[6:0];
      if (evt.addr_hit || evt.rx_done) data_q <= rx_byte;
      else if (we && addr == REG_AW'(RA_DATA)) data_q <= wdata;
      if (re) begin
        case (int'(addr))
          RA_CTRL: rdata <= {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q};
          RA_STAT: rdata <= st_q;
          RA_IEN:  rdata <= ien_q;
          RA_OWN:  rdata <= {1'b0, own};
          RA_DATA: rdata <= data_q;
          default: rdata <= '0;
        endcase
      end
    end
  end

  assign en       = ctrl_q[CB_EN];
  assign gce      = ctrl_q[CB_GCE];
  assign fna      = ctrl_q[CB_NAK];
  assign hold_any = st_q[SB_ADR] | st_q[SB_RXD] | st_q[SB_EMP];

  // R9: writing 0 to a flag clears it when no new event lands
  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_st && !wdata[SB_RXD] && !evt.rx_done) |=> !st_q[SB_RXD]);

  // R6: forced NACK is consumed by the byte it refused
  assert_fna_once_R6: assert property (@(posedge clk) disable iff (rst)
    (evt.nack_used && !wr_ctl) |=> !ctrl_q[CB_NAK]);

  // R10: a request never stands without an enabled flag
  assert_irq_src_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((st_q & ien_q) != '0));

  // R4: transmit-mode bit follows the matched R/W bit
  assert_mode_R4: assert property (@(posedge clk) disable iff (rst)
    evt.addr_hit |=> (st_q[SB_MOD] == $past(evt.rw)));
endmodule

// File: rtl/i2c_target.sv
module i2c_target
  import i2c_tgt_pkg::*;
#(
  parameter int REG_AW      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic en, gce, fna, hold_any;
  logic [6:0] own;
  logic [BYTE_W-1:0] data_q, rx_byte;
  tgt_evt_t evt;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_fsm u_fsm (
    .clk(clk), .rst(rst), .en(en), .gce(gce), .fna(fna), .own(own),
    .tx_byte(data_q), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_oe(sda_oe),
    .evt(evt), .rx_byte(rx_byte)
  );

  i2c_tgt_regs #(.REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .re(reg_re), .addr(reg_addr),
    .wdata(reg_wdata), .evt(evt), .rx_byte(rx_byte), .rdata(reg_rdata),
    .en(en), .gce(gce), .fna(fna), .own(own), .data_q(data_q),
    .hold_any(hold_any), .irq(irq)
  );

  // stretch: grab SCL only while it is already low, keep it until serviced
  always_ff @(posedge clk) begin
    if (rst) scl_oe <= 1'b0;
    else     scl_oe <= en && hold_any && (!scl_s || scl_oe);
  end

  // R11: no stretch without a pending flag
  assert_hold_cause_R11: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> $past(hold_any));

  // R11: a pending flag with SCL low always stretches
  assert_hold_taken_R11: assert property (@(posedge clk) disable iff (rst)
    (en && hold_any && !scl_s) |=> scl_oe);
endmodule

// File: tb/sim_i2c_target.sv
module sim_i2c_target;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int A_CTRL = 0, A_STAT = 1, A_IEN = 2, A_OWN = 3, A_DATA = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_line, sda_line;
  logic scl_oe, sda_oe, irq;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  i2c_target u0 (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  int checks = 0, fails = 0, stretch_cycles = 0;
  bit srv_on = 1'b0;
  logic [7:0] tx_q [16];
  logic [7:0] rx_log [16];
  logic [7:0] wq [16];
  int tx_i = 0, rx_n = 0;
  logic [7:0] sar_st = '0, sar_dat = '0;

  always @(negedge clk) if (scl_oe) stretch_cycles++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    reg_addr = 3'(a); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    reg_addr = 3'(a); reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  // software model: services the flags that hold the clock
  task automatic service();
    logic [7:0] s, d;
    rd(A_STAT, s);
    if (s[0]) begin
      sar_st = s;
      rd(A_DATA, d);
      sar_dat = d;
      if (s[5]) begin wr(A_DATA, tx_q[tx_i[3:0]]); tx_i++; end
      wr(A_STAT, 8'hFE);
    end else if (s[1]) begin
      rd(A_DATA, d);
      rx_log[rx_n[3:0]] = d; rx_n++;
      wr(A_STAT, 8'hFD);
    end else if (s[3]) begin
      wr(A_DATA, tx_q[tx_i[3:0]]); tx_i++;
      wr(A_STAT, 8'hF7);
    end else begin
      @(negedge clk);
    end
  endtask

  task automatic scl_high();
    scl_m = 1'b1;
    while (!scl_line) begin
      if (srv_on && irq) service();
      else @(negedge clk);
    end
  endtask

  task automatic m_start();
    sda_m = 1'b1; scl_m = 1'b1; hcyc(HALF);
    sda_m = 1'b0; hcyc(HALF);
    scl_m = 1'b0; hcyc(HALF);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; hcyc(HALF);
    scl_high(); hcyc(HALF);
    sda_m = 1'b1; hcyc(HALF);
  endtask

  task automatic m_bit_w(input logic b);
    sda_m = b; hcyc(HALF);
    scl_high(); hcyc(HALF);
    scl_m = 1'b0;
  endtask

  task automatic m_bit_r(output logic b);
    sda_m = 1'b1; hcyc(HALF);
    scl_high(); hcyc(HALF/2);
    b = sda_line; hcyc(HALF/2);
    scl_m = 1'b0;
  endtask

  task automatic m_wbyte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) m_bit_w(b[i]);
    m_bit_r(a);
    ack = ~a;
  endtask

  task automatic m_rbyte(output logic [7:0] b, input logic give_ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin m_bit_r(x); b[i] = x; end
    m_bit_w(~give_ack);
  endtask

  function automatic logic [7:0] exp_stat_after_read();
    return 8'h34; // mode + stop + sent
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, b;
    logic ack;
    int n;
    void'($urandom(32'd5150));
    hcyc(4); rst = 1'b0; hcyc(2);

    // R1 reset state
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 irq", irq, 0);
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_IEN, v);  chk("R1 ien", v, 0);

    wr(A_OWN, 8'h42); wr(A_IEN, 8'h0B); wr(A_CTRL, 8'h0C);
    srv_on = 1'b1;

    for (int r = 0; r < 6; r++) begin
      n = 1 + int'($urandom % 4);
      if (r % 2 == 0) begin
        rx_n = 0;
        for (int i = 0; i < n; i++) wq[i] = 8'($urandom);
        m_start();
        m_wbyte(8'h84, ack); chk("R2 addr ack (write)", ack, 1);
        for (int i = 0; i < n; i++) begin
          m_wbyte(wq[i], ack); chk("R5 data ack", ack, 1);
        end
        m_stop();
        chk("R5 byte count", rx_n, n);
        for (int i = 0; i < n; i++) chk("R5 byte value", rx_log[i], wq[i]);
        chk("R2 data reg holds address byte", sar_dat, 8'h84);
        chk("R4 mode bit on write", sar_st[5], 0);
        srv_on = 1'b0;
        rd(A_STAT, v); chk("R8 stop flag after write", v, 8'h10);
        wr(A_STAT, 8'h00); rd(A_STAT, v); chk("R9 clear all", v, 8'h00);
        srv_on = 1'b1;
      end else begin
        tx_i = 0;
        for (int i = 0; i < 16; i++) tx_q[i] = 8'($urandom);
        m_start();
        m_wbyte(8'h85, ack); chk("R2 addr ack (read)", ack, 1);
        for (int i = 0; i < n; i++) begin
          m_rbyte(b, i < n - 1); chk("R7 read byte", b, tx_q[i]);
        end
        m_stop();
        chk("R4 mode bit on read", sar_st[5], 1);
        srv_on = 1'b0;
        rd(A_STAT, v); chk("R7 flags after read", v, exp_stat_after_read());
        wr(A_STAT, 8'hFB); rd(A_STAT, v); chk("R9 clear sent only", v, 8'h30);
        wr(A_STAT, 8'h00); rd(A_STAT, v); chk("R9 mode bit kept", v, 8'h20);
        srv_on = 1'b1;
      end
    end
    chk("R11 clock was stretched", stretch_cycles > 0, 1);
    chk("R11 clock released", scl_oe, 0);

    // R3 non-matching address
    m_start(); m_wbyte(8'h60, ack); chk("R3 foreign address nack", ack, 0); m_stop();
    srv_on = 1'b0;
    rd(A_STAT, v); chk("R3 no address flag", v & 8'h41, 0);
    wr(A_STAT, 8'h00);
    srv_on = 1'b1;

    // R3 general call disabled then enabled
    m_start(); m_wbyte(8'h00, ack); chk("R3 general call off nack", ack, 0); m_stop();
    srv_on = 1'b0; wr(A_STAT, 8'h00); wr(A_CTRL, 8'h0E); srv_on = 1'b1;
    rx_n = 0;
    m_start();
    m_wbyte(8'h00, ack); chk("R3 general call on ack", ack, 1);
    m_wbyte(8'h5A, ack); chk("R5 general call data ack", ack, 1);
    m_stop();
    chk("R5 general call data", rx_log[0], 8'h5A);
    srv_on = 1'b0;
    rd(A_STAT, v); chk("R3 general call flag", v, 8'h50);
    wr(A_STAT, 8'h00);

    // R6 forced NACK
    wr(A_CTRL, 8'h0D); srv_on = 1'b1; rx_n = 0;
    m_start();
    m_wbyte(8'h84, ack); chk("R6 addr still acked", ack, 1);
    m_wbyte(8'hA5, ack); chk("R6 refused byte", ack, 0);
    m_wbyte(8'h3C, ack); chk("R6 following byte acked", ack, 1);
    m_stop();
    srv_on = 1'b0;
    rd(A_CTRL, v); chk("R6 bit self cleared", v, 8'h0C);
    chk("R5 byte after refusal", rx_log[1], 8'h3C);

    // R10 interrupt gating (stop flag is pending)
    wr(A_IEN, 8'h00); chk("R10 irq masked", irq, 0);
    wr(A_IEN, 8'h10); chk("R10 irq on enabled flag", irq, 1);
    wr(A_STAT, 8'h00); chk("R10 irq after clear", irq, 0);
    wr(A_IEN, 8'h0B);

    // R8 clock pulses without START are ignored
    scl_m = 1'b0; hcyc(HALF);
    for (int i = 7; i >= 0; i--) m_bit_w(v[i] ^ 1'b0 | 8'h84 >> i & 1'b1);
    m_bit_r(b[0]); chk("R8 no ack without start", b[0], 1);
    rd(A_STAT, v); chk("R8 no flags without start", v, 0);
    m_stop();
    wr(A_STAT, 8'h00);

    // R12 interface disabled
    wr(A_CTRL, 8'h08);
    m_start(); m_wbyte(8'h84, ack); chk("R12 no ack when off", ack, 0); m_stop();
    rd(A_STAT, v); chk("R12 no flags when off", v, 0);
    rd(A_CTRL, v); chk("R12 buffer select read back", v, 8'h08);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule